// File: doc/BRIEF.md
# Write-Only Cipher Key Store

This block keeps the secret keys used by a 128-bit block cipher engine. Software loads any of four key slots through a small register port. It first writes a slot index register. It then writes the key one 32-bit word at a time into a data register. After every data write the word pointer moves on to the next word by itself, so a full key takes one index write and four data writes. Key bits never come back on the read port: the data register always reads as zero.

A second key comes from a fuse controller after reset. It arrives as 128 parallel bits together with a capture strobe, and the block latches it into a dedicated slot. For each cipher operation, three select inputs decide which key reaches the cipher core. The fused key has top priority. A payload-supplied key comes next. When neither of those is requested, the stored slot named by the slot select is used. A request for the fused key before any capture has happened raises an error flag and drives an all-zero key.

Top module: `cipher_key_store`

## Requirements
- R1: A synchronous reset clears the slot index, the word pointer, all four stored slots and the fused slot, and marks the fused key as not yet captured.
- R2: A write to the data register (address 1) stores the write data into word `ptr` of slot `idx`, where word 0 occupies key bits [31:0] and word 3 occupies bits [127:96].
- R3: Each data register write advances the word pointer by one, and the pointer wraps from 3 back to 0.
- R4: A write to the index register (address 0) loads the slot index from write data bits [5:4] and sets the word pointer to 0.
- R5: A read of address 0 returns the slot index in bits [5:4] and the word pointer in bits [1:0], with every other bit zero. Addresses 2 and 3 read as zero.
- R6: A read of the data register (address 1) returns zero whatever the slots hold.
- R7: In any cycle where the capture strobe is high, the fused key input is latched into the fused slot, and the fused key is marked captured.
- R8: When the fused-key select is high, the key output is the fused slot and overrides the payload select. If no capture has happened since reset, the error output is high and the key output is zero.
- R9: When the payload select is high and the fused-key select is low, the key output equals the payload key input and the error output is low.
- R10: When both the fused-key select and the payload select are low, the key output is the stored slot named by the 2-bit slot select.
- R11: A data write changes only the addressed word of the addressed slot. Every other word and slot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 index, 1 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| otp_strobe | input | 1 | Fused key capture strobe |
| otp_key | input | 128 | Fused key value |
| sel_otp | input | 1 | Request the fused key |
| sel_payload | input | 1 | Request the payload key |
| sel_slot | input | 2 | Stored slot to use when no other source is requested |
| payload_key | input | 128 | Key supplied with the operation |
| key_out | output | 128 | Key presented to the cipher core |
| key_err | output | 1 | Fused key requested before capture |

## Verification
The bench builds the block with its default parameters: four slots, 128-bit keys and 32-bit words. With these values the four-step pointer wrap, every slot and the full set of select combinations can all be reached within a few hundred cycles. A behavioural model is compared on every clock with the read data, the key output and the error flag. The comparison covers the window before the first capture strobe, writes that run past the last word of a slot, and index changes made in the middle of a key.

// File: rtl/ck_pkg.sv
package ck_pkg;
    parameter int unsigned NUM_SLOTS = 4;
    parameter int unsigned KEY_W     = 128;
    parameter int unsigned WORD_W    = 32;
    parameter int unsigned REG_AW    = 2;

    localparam int unsigned WORDS  = KEY_W / WORD_W;
    localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
    localparam int unsigned PTR_W  = $clog2(WORDS);
    localparam int unsigned IDX_LSB = 4;

    localparam logic [REG_AW-1:0] ADDR_INDEX = REG_AW'(0);
    localparam logic [REG_AW-1:0] ADDR_DATA  = REG_AW'(1);

    typedef enum logic [1:0] {
        SRC_SLOT,
        SRC_PAYLOAD,
        SRC_OTP,
        SRC_BLOCKED
    } key_src_e;

    typedef struct packed {
        logic              we;
        logic [SLOT_W-1:0] slot;
        logic [PTR_W-1:0]  word;
        logic [WORD_W-1:0] data;
    } key_wr_t;

    function automatic key_src_e pick_src(input logic want_otp,
                                          input logic want_pay,
                                          input logic otp_ok);
        if (want_otp)      return otp_ok ? SRC_OTP : SRC_BLOCKED;
        else if (want_pay) return SRC_PAYLOAD;
        else               return SRC_SLOT;
    endfunction
endpackage

// File: rtl/ck_regif.sv
module ck_regif
    import ck_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output key_wr_t           wr
);
    logic [SLOT_W-1:0] idx_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              wr_index;
    logic              wr_data;

    assign wr_index = reg_wr && (reg_addr == ADDR_INDEX);
    assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ptr_q <= '0;
        end else if (wr_index) begin
            idx_q <= reg_wdata[IDX_LSB +: SLOT_W];
            ptr_q <= '0;
        end else if (wr_data) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    always_comb begin
        wr.we   = wr_data;
        wr.slot = idx_q;
        wr.word = ptr_q;
        wr.data = reg_wdata;
    end

    // Only the index register is ever readable; key words never are.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_INDEX) begin
            reg_rdata[IDX_LSB +: SLOT_W] = idx_q;
            reg_rdata[PTR_W-1:0]         = ptr_q;
        end
    end

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));

    p_idx_clear_ptr_r4: assert property (@(posedge clk) disable iff (rst)
        wr_index |=> (ptr_q == '0) && (idx_q == $past(reg_wdata[IDX_LSB +: SLOT_W])));

    p_data_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_DATA) |-> reg_rdata == '0);
endmodule

// File: rtl/ck_store.sv
module ck_store
    import ck_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  key_wr_t                         wr,
    input  logic                            otp_strobe,
    input  logic [KEY_W-1:0]                otp_key,
    output logic [NUM_SLOTS-1:0][KEY_W-1:0] slots,
    output logic [KEY_W-1:0]                otp_q,
    output logic                            otp_valid
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    slots[s][w*WORD_W +: WORD_W] <= '0;
                else if (wr.we && wr.slot == SLOT_W'(s) && wr.word == PTR_W'(w))
                    slots[s][w*WORD_W +: WORD_W] <= wr.data;
            end
        end

        p_slot_hold_r11: assert property (@(posedge clk) disable iff (rst)
            !(wr.we && wr.slot == SLOT_W'(s)) |=> $stable(slots[s]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            otp_q     <= '0;
            otp_valid <= 1'b0;
        end else if (otp_strobe) begin
            otp_q     <= otp_key;
            otp_valid <= 1'b1;
        end
    end

    p_otp_capture_r7: assert property (@(posedge clk) disable iff (rst)
        otp_strobe |=> otp_valid && (otp_q == $past(otp_key)));
endmodule

// File: rtl/ck_select.sv
module ck_select
    import ck_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            sel_otp,
    input  logic                            sel_payload,
    input  logic [SLOT_W-1:0]               sel_slot,
    input  logic [KEY_W-1:0]                payload_key,
    input  logic [NUM_SLOTS-1:0][KEY_W-1:0] slots,
    input  logic [KEY_W-1:0]                otp_q,
    input  logic                            otp_valid,
    output logic [KEY_W-1:0]                key_out,
    output logic                            key_err
);
    key_src_e src;

    assign src = pick_src(sel_otp, sel_payload, otp_valid);

    always_comb begin
        key_err = 1'b0;
        unique case (src)
            SRC_OTP:     key_out = otp_q;
            SRC_PAYLOAD: key_out = payload_key;
            SRC_SLOT:    key_out = slots[sel_slot];
            default: begin
                key_out = '0;
                key_err = 1'b1;
            end
        endcase
    end

    p_err_blank_r8: assert property (@(posedge clk) disable iff (rst)
        key_err |-> (key_out == '0) && sel_otp && !otp_valid);

    p_payload_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_payload && !sel_otp) |-> (key_out == payload_key) && !key_err);
endmodule

// File: rtl/cipher_key_store.sv
module cipher_key_store
    import ck_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    input  logic                     otp_strobe,
    input  logic [KEY_W-1:0]         otp_key,
    input  logic                     sel_otp,
    input  logic                     sel_payload,
    input  logic [SLOT_W-1:0]        sel_slot,
    input  logic [KEY_W-1:0]         payload_key,
    output logic [KEY_W-1:0]         key_out,
    output logic                     key_err
);
    key_wr_t                         wr;
    logic [NUM_SLOTS-1:0][KEY_W-1:0] slots;
    logic [KEY_W-1:0]                otp_q;
    logic                            otp_valid;

    ck_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr        (wr)
    );

    ck_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .otp_strobe (otp_strobe),
        .otp_key    (otp_key),
        .slots      (slots),
        .otp_q      (otp_q),
        .otp_valid  (otp_valid)
    );

    ck_select u_select (
        .clk         (clk),
        .rst         (rst),
        .sel_otp     (sel_otp),
        .sel_payload (sel_payload),
        .sel_slot    (sel_slot),
        .payload_key (payload_key),
        .slots       (slots),
        .otp_q       (otp_q),
        .otp_valid   (otp_valid),
        .key_out     (key_out),
        .key_err     (key_err)
    );
endmodule

// File: tb/cipher_key_store_tb_top.sv
module cipher_key_store_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MAX_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_wr;
    logic [1:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         otp_strobe;
    logic [127:0] otp_key;
    logic         sel_otp;
    logic         sel_payload;
    logic [1:0]   sel_slot;
    logic [127:0] payload_key;
    logic [127:0] key_out;
    logic         key_err;

    int n_cmp  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;
    bit do_cmp = 0;
    string tag = "R1";

    // behavioural reference state
    logic [127:0] m_slot [4];
    logic [127:0] m_otp;
    bit           m_otp_ok;
    int           m_idx;
    int           m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_key_store dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .otp_strobe(otp_strobe),
        .otp_key(otp_key), .sel_otp(sel_otp), .sel_payload(sel_payload),
        .sel_slot(sel_slot), .payload_key(payload_key), .key_out(key_out),
        .key_err(key_err)
    );

    task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0]  e_rd;
        logic [127:0] e_key;
        logic         e_err;
        e_rd = '0;
        if (reg_addr == 2'd0) begin
            e_rd[5:4] = m_idx[1:0];
            e_rd[1:0] = m_ptr[1:0];
        end
        e_err = 1'b0;
        if (sel_otp) begin
            e_key = m_otp_ok ? m_otp : '0;
            e_err = !m_otp_ok;
        end else if (sel_payload) begin
            e_key = payload_key;
        end else begin
            e_key = m_slot[sel_slot];
        end
        check("reg_rdata", 128'(reg_rdata), 128'(e_rd));
        check("key_out", key_out, e_key);
        check("key_err", 128'(key_err), 128'(e_err));
    endtask

    task automatic model_update();
        if (rst) begin
            m_idx = 0; m_ptr = 0; m_otp = '0; m_otp_ok = 0;
            for (int s = 0; s < 4; s++) m_slot[s] = '0;
        end else begin
            if (reg_wr && reg_addr == 2'd0) begin
                m_idx = int'(reg_wdata[5:4]);
                m_ptr = 0;
            end else if (reg_wr && reg_addr == 2'd1) begin
                m_slot[m_idx][m_ptr*32 +: 32] = reg_wdata;
                m_ptr = (m_ptr + 1) % 4;
            end
            if (otp_strobe) begin
                m_otp = otp_key;
                m_otp_ok = 1;
            end
        end
    endtask

    // inputs already set at the falling edge; compare, clock, update model
    task automatic tick();
        #1;
        if (do_cmp) compare();
        @(posedge clk);
        model_update();
        do_cmp = 1;
        @(negedge clk);
        reg_wr = 0; otp_strobe = 0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_addr = 2'd0;
    endtask

    initial begin
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        otp_strobe = 0; otp_key = 0; sel_otp = 0; sel_payload = 0;
        sel_slot = 0; payload_key = 0;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R1: reset state visible on index readback and blocked fused key
        tag = "R1"; sel_otp = 1; tick();
        tag = "R8"; sel_payload = 1; payload_key = {4{32'hA5A5_0F0F}}; tick();
        sel_otp = 0; tag = "R9"; tick();
        sel_payload = 0;
        // R4, R2, R3: load slot 2 and run past the last word
        tag = "R4"; wr_reg(2'd0, 32'h0000_0020); tick();
        tag = "R2";
        wr_reg(2'd1, 32'h1111_0000); wr_reg(2'd1, 32'h2222_0001);
        wr_reg(2'd1, 32'h3333_0002);
        tag = "R3"; wr_reg(2'd1, 32'h4444_0003); tick();
        wr_reg(2'd1, 32'h5555_0004);
        tag = "R10"; sel_slot = 2; tick();
        // R6: data register reads as zero
        tag = "R6"; reg_addr = 2'd1; tick();
        tag = "R5"; reg_addr = 2'd2; tick(); reg_addr = 2'd3; tick(); reg_addr = 0; tick();
        // R4: index change mid-key resets pointer; index bits outside field ignored
        tag = "R4"; wr_reg(2'd0, 32'hFFFF_FFDF); tick();
        tag = "R11";
        wr_reg(2'd1, 32'hDEAD_BEEF); wr_reg(2'd1, 32'hCAFE_F00D);
        for (int s = 0; s < 4; s++) begin sel_slot = 2'(s); tick(); end
        // R7, R8: capture fused key, then override payload
        tag = "R7"; otp_key = {32'h0BAD_F00D, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C};
        otp_strobe = 1; tick();
        tag = "R8"; sel_otp = 1; sel_payload = 1; tick(); sel_payload = 0; tick();
        tag = "R7"; otp_key = ~otp_key; otp_strobe = 1; tick(); tick();
        sel_otp = 0;
        // mixed traffic
        tag = "R11";
        for (int i = 0; i < 400; i++) begin
            reg_wr      = ($urandom_range(0, 2) != 0);
            reg_addr    = 2'($urandom_range(0, 3));
            reg_wdata   = $urandom;
            otp_strobe  = ($urandom_range(0, 15) == 0);
            otp_key     = {$urandom, $urandom, $urandom, $urandom};
            sel_otp     = ($urandom_range(0, 3) == 0);
            sel_payload = ($urandom_range(0, 2) == 0);
            sel_slot    = 2'($urandom_range(0, 3));
            payload_key = {$urandom, $urandom, $urandom, $urandom};
            tick();
        end
        // R1: reset again clears slots and fused key
        tag = "R1"; rst = 1; tick(); rst = 0; sel_otp = 0; sel_payload = 0;
        for (int s = 0; s < 4; s++) begin sel_slot = 2'(s); tick(); end
        sel_otp = 1; tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule